// File: doc/BRIEF.md
# Processor Interrupt Vectoring Controller

This block sits beside a processor pipeline and decides which exception the core enters next. It watches a reset request, a non-maskable interrupt line, twelve maskable request lines and two pulses from the instruction decoder: one for a software-interrupt instruction and one for an illegal opcode. It gates each source with its enables and picks one winner by fixed priority. It then reports the winner as a one-cycle acknowledge pulse carrying a source number and the vector address that the program counter should load.

On entry the block latches the interrupted program counter into the return pointer for that kind of source. For ordinary entries (software, illegal opcode, maskable) it also copies the status word, the eight general registers and every loop start, end and count register into a shadow bank, and clears the global enable bit. Non-maskable entry saves only the status word, into a save register of its own, and uses a return pointer of its own. A return strobe of the matching kind restores the saved state in one cycle.

A four-state machine tracks which handler is running. In `ST_RUN` no handler is active. In `ST_SVC` an ordinary handler is active. In `ST_NMI` a non-maskable handler is active that was entered from `ST_RUN`. In `ST_NMI_IN_SVC` a non-maskable handler is active that preempted an ordinary one. The transitions are:
- RUN to SVC on an ordinary acknowledge.
- RUN to NMI on a non-maskable acknowledge.
- SVC to NMI_IN_SVC on a non-maskable acknowledge.
- SVC to RUN on an interrupt return.
- NMI to RUN on a non-maskable return.
- NMI_IN_SVC to SVC on a non-maskable return.
- Any state to RUN on a reset request.

Top module: `intr_vector_ctrl`

## Requirements
- R1: Source numbers are: reset 0, non-maskable 1, software 2, illegal opcode 3, and maskable line k (irq_i[k]) is 4+k. The vector output equals four times the acknowledged source number, so reset gives 0x00, line irq_i[11] gives 0x3C, and so on.
- R2: When several enabled sources are pending in the same cycle, the one acknowledged is chosen in this order, highest first: reset, non-maskable, illegal opcode, software, then irq_i[0] down to irq_i[11].
- R3: A maskable line is acknowledged only when three conditions hold together: status bit 0 (global enable) is set, nmi_en_i is set, and its own line_en_i bit is set.
- R4: The non-maskable request is acknowledged only when nmi_en_i is set.
- R5: On a non-maskable acknowledge, nrp_o takes pc_i and nmi_csr_o takes the current status word. irp_o and the shadow bank are left unchanged.
- R6: On an ordinary acknowledge, several things happen at once. irp_o takes pc_i. The shadow bank captures the status word, gpr_i and loop_i, which show on scsr_o, gpr_sh_o and loop_sh_o. Status bit 0 is cleared.
- R7: An accepted rti_i in state SVC reloads the status word from scsr_o and raises restore_o for exactly one cycle. An accepted nrti_i reloads the status word from nmi_csr_o and does not raise restore_o.
- R8: A reset request is always acknowledged as source 0 with vector 0. It clears the status word and moves the state to RUN. It leaves both return pointers unchanged.
- R9: The software and illegal-opcode pulses need no enable bit. A pulse that cannot be taken at once stays pending until it is acknowledged or a reset request arrives.
- R10: In SVC, only reset and non-maskable requests are acknowledged. In NMI or NMI_IN_SVC, only reset is acknowledged. A non-maskable return from NMI_IN_SVC goes back to SVC.
- R11: Requests sampled at a clock edge produce ack_o, ack_id_o and vec_o on the next cycle. ack_o is high for a single cycle for each acknowledge. Maskable lines are level-sensitive and keep requesting while held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| reset_req_i | input | 1 | Reset exception request |
| nmi_i | input | 1 | Non-maskable request, level |
| irq_i | input | N_LINES | Maskable request lines, level |
| swi_i | input | 1 | Software-interrupt decode pulse |
| undef_i | input | 1 | Illegal-opcode decode pulse |
| nmi_en_i | input | 1 | Non-maskable enable, also gates all maskable lines |
| line_en_i | input | N_LINES | Per-line enables |
| csr_wr_i | input | 1 | Status word write strobe |
| csr_wdata_i | input | CSR_W | Status word write data |
| pc_i | input | PC_W | Return address to latch on entry |
| gpr_i | input | N_GPR*DATA_W | Live general registers |
| loop_i | input | 3*N_LOOP*DATA_W | Live loop start/end/count registers |
| rti_i | input | 1 | Ordinary interrupt return strobe |
| nrti_i | input | 1 | Non-maskable return strobe |
| ack_o | output | 1 | Acknowledge pulse |
| ack_id_o | output | clog2(4+N_LINES) | Acknowledged source number |
| vec_o | output | PC_W | Vector address |
| irp_o | output | PC_W | Ordinary return pointer |
| nrp_o | output | PC_W | Non-maskable return pointer |
| csr_o | output | CSR_W | Current status word |
| scsr_o | output | CSR_W | Shadowed status word |
| nmi_csr_o | output | CSR_W | Status word saved on non-maskable entry |
| restore_o | output | 1 | One-cycle pulse: shadow registers to be reloaded |
| gpr_sh_o | output | N_GPR*DATA_W | Shadow general registers |
| loop_sh_o | output | 3*N_LOOP*DATA_W | Shadow loop registers |

## Verification
Every result of this block lands one cycle after the edge that sampled its cause. Acknowledge, source number, vector, return pointers, shadow contents and the cleared enable bit all appear together on the cycle after the request edge. restore_o and the reloaded status word appear on the cycle after the return strobe. A pending software pulse held back during a handler is acknowledged one cycle after the return. The bench drives inputs on falling edges and reads outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. Where an output must stay quiet, such as a blocked line inside a handler, the bench also checks the falling edge after that.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SVC,
        ST_NMI,
        ST_NMI_IN_SVC
    } ivc_state_e;

    localparam int unsigned SRC_RESET  = 0;
    localparam int unsigned SRC_NMI    = 1;
    localparam int unsigned SRC_SWI    = 2;
    localparam int unsigned SRC_UNDEF  = 3;
    localparam int unsigned FIRST_LINE = 4;
    localparam int unsigned GIE_BIT    = 0;

endpackage

// File: rtl/ivc_prio_arbiter.sv
module ivc_prio_arbiter #(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned ID_W  = 4
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             valid_o,
    output logic [ID_W-1:0]  id_o
);
    // Lowest-priority candidates are visited first so later hits override.
    always_comb begin
        valid_o = |req_i;
        id_o    = '0;
        for (int i = N_SRC - 1; i >= int'(ivc_pkg::FIRST_LINE); i--) begin
            if (req_i[i]) id_o = ID_W'(i);
        end
        if (req_i[ivc_pkg::SRC_SWI])   id_o = ID_W'(ivc_pkg::SRC_SWI);
        if (req_i[ivc_pkg::SRC_UNDEF]) id_o = ID_W'(ivc_pkg::SRC_UNDEF);
        if (req_i[ivc_pkg::SRC_NMI])   id_o = ID_W'(ivc_pkg::SRC_NMI);
        if (req_i[ivc_pkg::SRC_RESET]) id_o = ID_W'(ivc_pkg::SRC_RESET);
    end
endmodule

// File: rtl/ivc_shadow_bank.sv
module ivc_shadow_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         save_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= '0;
        else if (save_i) q_o <= d_i;
    end
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned N_LINES = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned CSR_W   = 16,
    parameter int unsigned N_GPR   = 8,
    parameter int unsigned N_LOOP  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   reset_req_i,
    input  logic                                   nmi_i,
    input  logic [N_LINES-1:0]                     irq_i,
    input  logic                                   swi_i,
    input  logic                                   undef_i,
    input  logic                                   nmi_en_i,
    input  logic [N_LINES-1:0]                     line_en_i,
    input  logic                                   csr_wr_i,
    input  logic [CSR_W-1:0]                       csr_wdata_i,
    input  logic [PC_W-1:0]                        pc_i,
    input  logic [N_GPR*DATA_W-1:0]                gpr_i,
    input  logic [3*N_LOOP*DATA_W-1:0]             loop_i,
    input  logic                                   rti_i,
    input  logic                                   nrti_i,
    output logic                                   ack_o,
    output logic [$clog2(FIRST_LINE+N_LINES)-1:0]  ack_id_o,
    output logic [PC_W-1:0]                        vec_o,
    output logic [PC_W-1:0]                        irp_o,
    output logic [PC_W-1:0]                        nrp_o,
    output logic [CSR_W-1:0]                       csr_o,
    output logic [CSR_W-1:0]                       scsr_o,
    output logic [CSR_W-1:0]                       nmi_csr_o,
    output logic                                   restore_o,
    output logic [N_GPR*DATA_W-1:0]                gpr_sh_o,
    output logic [3*N_LOOP*DATA_W-1:0]             loop_sh_o
);
    localparam int unsigned N_SRC  = FIRST_LINE + N_LINES;
    localparam int unsigned ID_W   = $clog2(N_SRC);
    localparam int unsigned GPR_W  = N_GPR * DATA_W;
    localparam int unsigned LOOP_W = 3 * N_LOOP * DATA_W;
    localparam int unsigned BANK_W = CSR_W + GPR_W + LOOP_W;

    ivc_state_e        state_q, state_d;
    logic [CSR_W-1:0]  csr_q;
    logic              swi_pend_q, undef_pend_q;
    logic [N_SRC-1:0]  req;
    logic              take;
    logic [ID_W-1:0]   take_id;
    logic              allow_ord, allow_nmi, gie;
    logic              take_rst, take_nmi, take_ord, do_rti, do_nrti;
    logic [BANK_W-1:0] bank_q;

    assign gie       = csr_q[GIE_BIT];
    assign allow_ord = (state_q == ST_RUN);
    assign allow_nmi = (state_q == ST_RUN) || (state_q == ST_SVC);

    // Request gating
    assign req[SRC_RESET] = reset_req_i;
    assign req[SRC_NMI]   = nmi_i & nmi_en_i & allow_nmi;
    assign req[SRC_SWI]   = (swi_i | swi_pend_q) & allow_ord;
    assign req[SRC_UNDEF] = (undef_i | undef_pend_q) & allow_ord;

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        assign req[FIRST_LINE + k] = irq_i[k] & line_en_i[k] & nmi_en_i & gie & allow_ord;
    end

    ivc_prio_arbiter #(.N_SRC(N_SRC), .ID_W(ID_W)) arb_i (
        .req_i   (req),
        .valid_o (take),
        .id_o    (take_id)
    );

    // Action decode and next state
    always_comb begin
        take_rst = take && (take_id == ID_W'(SRC_RESET));
        take_nmi = take && (take_id == ID_W'(SRC_NMI));
        take_ord = take && (take_id >= ID_W'(SRC_SWI));
        do_rti   = rti_i && (state_q == ST_SVC) && !take_rst && !take_nmi;
        do_nrti  = nrti_i && ((state_q == ST_NMI) || (state_q == ST_NMI_IN_SVC)) && !take_rst;
        state_d  = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take_nmi)      state_d = ST_NMI;
                else if (take_ord) state_d = ST_SVC;
            end
            ST_SVC: begin
                if (take_nmi)    state_d = ST_NMI_IN_SVC;
                else if (do_rti) state_d = ST_RUN;
            end
            ST_NMI: begin
                if (do_nrti) state_d = ST_RUN;
            end
            ST_NMI_IN_SVC: begin
                if (do_nrti) state_d = ST_SVC;
            end
            default: state_d = ST_RUN;
        endcase
        if (take_rst) state_d = ST_RUN;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Status word and pending decoder pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q        <= '0;
            swi_pend_q   <= 1'b0;
            undef_pend_q <= 1'b0;
        end else begin
            if (take_rst)      csr_q <= '0;
            else if (take_ord) csr_q <= csr_q & ~(CSR_W'(1) << GIE_BIT);
            else if (do_rti)   csr_q <= scsr_o;
            else if (do_nrti)  csr_q <= nmi_csr_o;
            else if (csr_wr_i) csr_q <= csr_wdata_i;

            if (take_rst || (take && take_id == ID_W'(SRC_SWI)))        swi_pend_q <= 1'b0;
            else if (swi_i)                                               swi_pend_q <= 1'b1;
            if (take_rst || (take && take_id == ID_W'(SRC_UNDEF)))      undef_pend_q <= 1'b0;
            else if (undef_i)                                             undef_pend_q <= 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o     <= 1'b0;
            ack_id_o  <= '0;
            vec_o     <= '0;
            irp_o     <= '0;
            nrp_o     <= '0;
            restore_o <= 1'b0;
        end else begin
            ack_o     <= take;
            restore_o <= do_rti;
            if (take) begin
                ack_id_o <= take_id;
                vec_o    <= PC_W'(take_id) << 2;
            end
            if (take_ord) irp_o <= pc_i;
            if (take_nmi) nrp_o <= pc_i;
        end
    end

    // Shadow storage: full bank for ordinary entry, status only for NMI entry
    ivc_shadow_bank #(.W(BANK_W)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .save_i (take_ord),
        .d_i    ({csr_q, gpr_i, loop_i}),
        .q_o    (bank_q)
    );

    ivc_shadow_bank #(.W(CSR_W)) nmi_save_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .save_i (take_nmi),
        .d_i    (csr_q),
        .q_o    (nmi_csr_o)
    );

    assign scsr_o    = bank_q[BANK_W-1 -: CSR_W];
    assign gpr_sh_o  = bank_q[LOOP_W +: GPR_W];
    assign loop_sh_o = bank_q[LOOP_W-1:0];
    assign csr_o     = csr_q;

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
    parameter int unsigned N_LINES = 12,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned CSR_W   = 16,
    parameter int unsigned ID_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nmi_en_i,
    input logic [N_LINES-1:0] line_en_i,
    input logic [PC_W-1:0]    pc_i,
    input logic               ack_o,
    input logic [ID_W-1:0]    ack_id_o,
    input logic [PC_W-1:0]    irp_o,
    input logic [PC_W-1:0]    nrp_o,
    input logic [CSR_W-1:0]   csr_o,
    input logic [CSR_W-1:0]   scsr_o,
    input logic               restore_o
);
    logic [N_LINES-1:0] en_prev;
    always_ff @(posedge clk) en_prev <= line_en_i;

    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && ack_id_o == ID_W'(1) |-> $past(nmi_en_i)); // R4
    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && ack_id_o >= ID_W'(4) |-> $past(nmi_en_i) && en_prev[int'(ack_id_o) - 4]); // R3
    AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && ack_id_o >= ID_W'(2) |-> !csr_o[0]); // R6
    AST_IRP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && ack_id_o >= ID_W'(2) |-> irp_o == $past(pc_i)); // R6
    AST_NRP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && ack_id_o == ID_W'(1) |-> nrp_o == $past(pc_i)); // R5
    AST_RESTORE_CSR: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |-> csr_o == scsr_o); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && ack_id_o == ID_W'(0) |-> csr_o == '0); // R8
    AST_NO_ORD_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o && ack_id_o >= ID_W'(2) |=> !ack_o || ack_id_o <= ID_W'(1)); // R10
endmodule

bind intr_vector_ctrl ivc_checker #(
    .N_LINES (N_LINES),
    .PC_W    (PC_W),
    .CSR_W   (CSR_W),
    .ID_W    ($clog2(ivc_pkg::FIRST_LINE + N_LINES))
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_en_i  (nmi_en_i),
    .line_en_i (line_en_i),
    .pc_i      (pc_i),
    .ack_o     (ack_o),
    .ack_id_o  (ack_id_o),
    .irp_o     (irp_o),
    .nrp_o     (nrp_o),
    .csr_o     (csr_o),
    .scsr_o    (scsr_o),
    .restore_o (restore_o)
);

// File: tb/intr_vector_ctrl_tb_top.sv
module intr_vector_ctrl_tb_top;
    localparam int NL = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reset_req_i = 0, nmi_i = 0, swi_i = 0, undef_i = 0;
    logic [NL-1:0]  irq_i = '0, line_en_i = '0;
    logic           nmi_en_i = 0, csr_wr_i = 0, rti_i = 0, nrti_i = 0;
    logic [15:0]    csr_wdata_i = '0;
    logic [31:0]    pc_i = '0;
    logic [255:0]   gpr_i = '0;
    logic [191:0]   loop_i = '0;
    logic           ack_o, restore_o;
    logic [3:0]     ack_id_o;
    logic [31:0]    vec_o, irp_o, nrp_o;
    logic [15:0]    csr_o, scsr_o, nmi_csr_o;
    logic [255:0]   gpr_sh_o;
    logic [191:0]   loop_sh_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    intr_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reset_req_i(reset_req_i), .nmi_i(nmi_i),
        .irq_i(irq_i), .swi_i(swi_i), .undef_i(undef_i), .nmi_en_i(nmi_en_i),
        .line_en_i(line_en_i), .csr_wr_i(csr_wr_i), .csr_wdata_i(csr_wdata_i),
        .pc_i(pc_i), .gpr_i(gpr_i), .loop_i(loop_i), .rti_i(rti_i), .nrti_i(nrti_i),
        .ack_o(ack_o), .ack_id_o(ack_id_o), .vec_o(vec_o), .irp_o(irp_o),
        .nrp_o(nrp_o), .csr_o(csr_o), .scsr_o(scsr_o), .nmi_csr_o(nmi_csr_o),
        .restore_o(restore_o), .gpr_sh_o(gpr_sh_o), .loop_sh_o(loop_sh_o)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int rank(input int id);
        if (id == 2) return 3;
        if (id == 3) return 2;
        return id;
    endfunction

    // Release all requests and leave every handler, ignoring what gets taken.
    task automatic drain();
        reset_req_i = 0; nmi_i = 0; irq_i = '0; swi_i = 0; undef_i = 0; csr_wr_i = 0;
        for (int k = 0; k < 8; k++) begin
            if (ack_o) begin
                if (int'(ack_id_o) >= 2)      rti_i  = 1;
                else if (int'(ack_id_o) == 1) nrti_i = 1;
            end
            @(negedge clk);
            rti_i = 0; nrti_i = 0;
        end
    endtask

    task automatic trial(input logic [15:0] mask, input bit gie, input bit nmie,
                         input logic [NL-1:0] len, input bit exp_take, input int exp_id,
                         input string rq);
        @(negedge clk);
        csr_wr_i = 1; csr_wdata_i = {15'h1234, gie};
        nmi_en_i = nmie; line_en_i = len;
        @(negedge clk);
        csr_wr_i = 0;
        reset_req_i = mask[0]; nmi_i = mask[1]; swi_i = mask[2]; undef_i = mask[3];
        irq_i = mask[15:4];
        @(negedge clk);
        chk(ack_o == exp_take, rq, 64'(ack_o), 64'(exp_take));
        if (exp_take) begin
            chk(int'(ack_id_o) == exp_id, rq, 64'(ack_id_o), 64'(exp_id));
            chk(vec_o == 32'(exp_id * 4), {rq, "/R1"}, 64'(vec_o), 64'(exp_id * 4));
        end
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R11 watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0]  irp_keep;
        logic [255:0] g1;
        logic [191:0] l1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk(ack_o == 0 && restore_o == 0, "R11 reset idle", 64'(ack_o), 0);
        chk(csr_o == 0, "R8 reset csr", 64'(csr_o), 0);

        // R3: full enable sweep for every maskable line
        for (int ln = 0; ln < NL; ln++) begin
            for (int c = 0; c < 8; c++) begin
                logic [NL-1:0] len;
                len = ~(NL'(1) << ln) | (NL'(c[2]) << ln);
                trial(16'(1) << (ln + 4), c[0], c[1], len, c[0] & c[1] & c[2], ln + 4, "R3 line gating");
            end
        end

        // R4: non-maskable gating
        trial(16'h0002, 0, 0, '1, 0, 1, "R4 nmi disabled");
        trial(16'h0002, 0, 1, '1, 1, 1, "R4 nmi enabled");

        // R9: decoder pulses need no enables
        trial(16'h0004, 0, 0, '0, 1, 2, "R9 swi always enabled");
        trial(16'h0008, 0, 0, '0, 1, 3, "R9 undef always enabled");

        // R2: every pair of sources, all enabled
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                int w;
                w = (rank(a) < rank(b)) ? a : b;
                trial((16'(1) << a) | (16'(1) << b), 1, 1, '1, 1, w, "R2 priority pair");
            end
        end

        // R6: ordinary entry
        g1 = {8{32'hC0DE_0001}} ^ 256'h1234_5678;
        l1 = {6{32'h0BAD_F00D}} ^ 192'h55;
        @(negedge clk);
        csr_wr_i = 1; csr_wdata_i = 16'hA5A1; nmi_en_i = 1; line_en_i = '1;
        @(negedge clk);
        csr_wr_i = 0; irq_i = 12'h008; pc_i = 32'h0000_4440; gpr_i = g1; loop_i = l1;
        @(negedge clk);
        irq_i = '0;
        chk(ack_o && ack_id_o == 7, "R6 entry id", 64'(ack_id_o), 7);
        chk(irp_o == 32'h0000_4440, "R6 irp", 64'(irp_o), 64'h4440);
        chk(scsr_o == 16'hA5A1, "R6 scsr", 64'(scsr_o), 64'hA5A1);
        chk(gpr_sh_o == g1, "R6 gpr shadow", 64'(gpr_sh_o), 64'(g1));
        chk(loop_sh_o == l1, "R6 loop shadow", 64'(loop_sh_o), 64'(l1));
        chk(csr_o == 16'hA5A0, "R6 gie cleared", 64'(csr_o), 64'hA5A0);

        // R10: inside ordinary handler a maskable line is blocked even with GIE set
        csr_wr_i = 1; csr_wdata_i = 16'h00F1; gpr_i = ~g1;
        @(negedge clk);
        csr_wr_i = 0; irq_i = 12'h001;
        @(negedge clk);
        chk(ack_o == 0, "R10 no nesting in SVC", 64'(ack_o), 0);

        // R5: non-maskable preempts
        nmi_i = 1; pc_i = 32'h0000_8880;
        @(negedge clk);
        nmi_i = 0;
        chk(ack_o && ack_id_o == 1, "R5 nmi id", 64'(ack_id_o), 1);
        chk(nrp_o == 32'h0000_8880, "R5 nrp", 64'(nrp_o), 64'h8880);
        chk(nmi_csr_o == 16'h00F1, "R5 nmi csr", 64'(nmi_csr_o), 64'h00F1);
        chk(irp_o == 32'h0000_4440, "R5 irp untouched", 64'(irp_o), 64'h4440);
        chk(gpr_sh_o == g1, "R5 shadow untouched", 64'(gpr_sh_o), 64'(g1));
        csr_wr_i = 1; csr_wdata_i = 16'h0000;
        @(negedge clk);
        csr_wr_i = 0; nrti_i = 1;
        chk(ack_o == 0, "R10 no ack in NMI", 64'(ack_o), 0);
        @(negedge clk);
        nrti_i = 0;
        chk(csr_o == 16'h00F1, "R7 nrti csr", 64'(csr_o), 64'h00F1);
        chk(restore_o == 0, "R7 nrti no restore", 64'(restore_o), 0);
        chk(ack_o == 0, "R10 back in SVC", 64'(ack_o), 0);
        @(negedge clk);
        chk(ack_o == 0, "R10 SVC still blocks", 64'(ack_o), 0);

        // R7: ordinary return
        rti_i = 1;
        @(negedge clk);
        rti_i = 0;
        chk(restore_o == 1, "R7 restore pulse", 64'(restore_o), 1);
        chk(csr_o == 16'hA5A1, "R7 csr restored", 64'(csr_o), 64'hA5A1);
        chk(gpr_sh_o == g1, "R7 gpr restore data", 64'(gpr_sh_o), 64'(g1));
        chk(loop_sh_o == l1, "R7 loop restore data", 64'(loop_sh_o), 64'(l1));
        @(negedge clk);
        chk(restore_o == 0, "R7 restore one cycle", 64'(restore_o), 0);
        chk(ack_o && ack_id_o == 4, "R11 held line taken after return", 64'(ack_id_o), 4);
        @(negedge clk);
        chk(ack_o == 0, "R11 ack one cycle", 64'(ack_o), 0);
        irq_i = '0;

        // R8: reset request from inside a handler
        irp_keep = irp_o;
        reset_req_i = 1; pc_i = 32'h0000_CCC0;
        @(negedge clk);
        reset_req_i = 0;
        chk(ack_o && ack_id_o == 0, "R8 reset id", 64'(ack_id_o), 0);
        chk(vec_o == 0, "R8 reset vector", 64'(vec_o), 0);
        chk(csr_o == 0, "R8 csr cleared", 64'(csr_o), 0);
        chk(irp_o == irp_keep, "R8 irp kept", 64'(irp_o), 64'(irp_keep));
        chk(nrp_o == 32'h0000_8880, "R8 nrp kept", 64'(nrp_o), 64'h8880);

        // R9: swi pulse held pending across a handler
        csr_wr_i = 1; csr_wdata_i = 16'h0001;
        @(negedge clk);
        csr_wr_i = 0; irq_i = 12'h020;
        @(negedge clk);
        irq_i = '0;
        chk(ack_o && ack_id_o == 9, "R9 setup line", 64'(ack_id_o), 9);
        swi_i = 1;
        @(negedge clk);
        swi_i = 0; rti_i = 1;
        chk(ack_o == 0, "R9 swi held in SVC", 64'(ack_o), 0);
        @(negedge clk);
        rti_i = 0;
        chk(restore_o == 1, "R7 second restore", 64'(restore_o), 1);
        @(negedge clk);
        chk(ack_o && ack_id_o == 2, "R9 pending swi taken", 64'(ack_id_o), 2);
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule